// File: doc/BRIEF.md
# FIFO-Decoupled 16:1 Word Serializer

This block turns a stream of 16-bit parallel words into a single-bit serial stream. Words are written by an upstream word clock into a small asynchronous FIFO, one word on every rising edge of that clock. On the other side of the FIFO, the serial clock drives a divide-by-16 counter. At the end of each 16-cycle frame the counter loads the next word into a shift register. The shift register then sends that word out one bit per serial clock, most significant bit first.

The same divided clock leaves the block as a word-rate clock. Upstream logic can run on it, so its write rate is tied to the serializer's read rate in both frequency and phase. After reset the read side stays idle until the FIFO has filled up to a threshold, which puts the fill level near the middle. From then on, an empty FIFO at a load point sends an all-zero word. A write into a full FIFO is discarded. Each of these events sets its own sticky flag.

Top module: `ser16_serializer`

## Requirements
- R1: One 16-bit word from `wr_data` is captured on every rising `wr_clk` edge while `rst` is low; there is no write-enable. Accepted words are sent in the order they were written.
- R2: `word_clk_out` repeats every 16 `ser_clk` cycles. After reset is released it is low for the first 8 rising `ser_clk` edges and high for the next 8. It falls on the same edge that loads the shift register.
- R3: The shift register is loaded on the 16th rising `ser_clk` edge after reset release and on every 16th edge after that. `ser_out` gives bit 15 of the loaded word first and bit 0 last, one bit per `ser_clk` cycle. The next word's bit 15 follows bit 0 with no gap.
- R4: While `rst` is high, `ser_out`, `word_clk_out`, `underflow` and `overflow` are 0. `ser_out` stays 0 until the first load after reset release.
- R5: After reset, no written word is loaded until at least 4 words have been written. Until then each load sends an all-zero word and does not set `underflow`.
- R6: Once the prefill level has been reached, a load with the FIFO empty sends an all-zero word and sets `underflow`. `underflow` changes only on a load edge. A load with the FIFO not empty sends the oldest stored word.
- R7: The FIFO holds 8 words. A write while the FIFO is full is discarded and sets `overflow`.
- R8: `underflow` and `overflow` stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Upstream word clock; captures `wr_data` on rising edges |
| wr_data | input | 16 | Parallel word to be serialized |
| ser_clk | input | 1 | Serial bit clock |
| rst | input | 1 | Active-high synchronous reset, held across edges of both clocks |
| ser_out | output | 1 | Serial data, most significant bit first |
| word_clk_out | output | 1 | Word-rate clock, `ser_clk` divided by 16 |
| underflow | output | 1 | Sticky: a word was needed while the FIFO was empty (`ser_clk` domain) |
| overflow | output | 1 | Sticky: a word was written into a full FIFO (`wr_clk` domain) |

## Verification
The hardest states to reach from the ports are the two FIFO limits. At the matched word rate the fill level stays near its midpoint, so neither flag would ever be set. The stimulus gates the word clock off for many frames, which drains the FIFO and leads to zero words and an underflow, and then restarts it to show that sending resumes without a new prefill. After a reset, it runs the word clock eight times faster until writes are dropped. Every word written carries bit 15 set, so the model can tell a real word from a zero fill by the first bit of each frame.

// File: rtl/ser16_pkg.sv
package ser16_pkg;
  // Read-side phase: waiting for the prefill level, or streaming
  typedef enum logic {RD_FILL, RD_RUN} rd_state_e;
endpackage

// File: rtl/ser16_sync.sv
module ser16_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ser16_ram.sv
module ser16_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Slot being read was written at least two synchronizer stages earlier
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ser16_wr_ctrl.sv
module ser16_wr_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W:0]   rgray_s,
  output logic [ADDR_W:0]   wgray_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              we_o,
  output logic              ovf_o
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wbin, wbin_nxt;
  logic             full;

  assign wbin_nxt = wbin + 1'b1;
  // Full: write pointer one lap ahead of the synchronized read pointer
  assign full     = (wgray_o == {~rgray_s[PTR_W-1:PTR_W-2], rgray_s[PTR_W-3:0]});
  assign we_o     = !rst && !full;
  assign waddr_o  = wbin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray_o <= '0;
      ovf_o   <= 1'b0;
    end else if (full) begin
      ovf_o   <= 1'b1;
    end else begin
      wbin    <= wbin_nxt;
      wgray_o <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end
endmodule

// File: rtl/ser16_rd_shift.sv
module ser16_rd_shift
  import ser16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int PREFILL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W:0]   rgray_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              ser_o,
  output logic              word_clk_o,
  output logic              udf_o
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(DATA_W);
  localparam int HALF  = DATA_W / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [PTR_W-1:0]  wbin_s, rbin, rbin_nxt, level;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [DATA_W-1:0] shreg;
  logic              load, empty;
  rd_state_e         state;

  always_comb begin
    for (int i = 0; i < PTR_W; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign level    = wbin_s - rbin;
  assign empty    = (level == '0);
  assign load     = (cnt == LAST);
  assign cnt_nxt  = load ? '0 : cnt + 1'b1;
  assign rbin_nxt = rbin + 1'b1;
  assign raddr_o  = rbin[ADDR_W-1:0];
  assign ser_o    = shreg[DATA_W-1];

  // Divider and word-rate clock
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      word_clk_o <= 1'b0;
    end else begin
      cnt        <= cnt_nxt;
      word_clk_o <= (32'(cnt_nxt) >= HALF);
    end
  end

  // Prefill gate
  always_ff @(posedge clk) begin
    if (rst)                                            state <= RD_FILL;
    else if (state == RD_FILL && 32'(level) >= PREFILL) state <= RD_RUN;
  end

  // Load / shift and read pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      rbin    <= '0;
      rgray_o <= '0;
      udf_o   <= 1'b0;
    end else if (load) begin
      if (state == RD_RUN && !empty) begin
        shreg   <= rd_data;
        rbin    <= rbin_nxt;
        rgray_o <= rbin_nxt ^ (rbin_nxt >> 1);
      end else begin
        shreg   <= '0;
        if (state == RD_RUN) udf_o <= 1'b1;
      end
    end else begin
      shreg <= {shreg[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ser16_serializer.sv
module ser16_serializer #(
  parameter int WORD_W  = 16,
  parameter int FIFO_AW = 3,
  parameter int PREFILL = 4
) (
  input  logic              wr_clk,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              ser_clk,
  input  logic              rst,
  output logic              ser_out,
  output logic              word_clk_out,
  output logic              underflow,
  output logic              overflow
);
  localparam int PTR_W = FIFO_AW + 1;

  logic [PTR_W-1:0]   wgray, rgray, wgray_s, rgray_s;
  logic [FIFO_AW-1:0] waddr, raddr;
  logic [WORD_W-1:0]  rd_data;
  logic               we;

  ser16_wr_ctrl #(.ADDR_W(FIFO_AW)) u_wr (
    .clk(wr_clk), .rst(rst), .rgray_s(rgray_s),
    .wgray_o(wgray), .waddr_o(waddr), .we_o(we), .ovf_o(overflow)
  );

  ser16_ram #(.DATA_W(WORD_W), .ADDR_W(FIFO_AW)) u_ram (
    .wr_clk(wr_clk), .wr_en(we), .wr_addr(waddr), .wr_data(wr_data),
    .rd_addr(raddr), .rd_data(rd_data)
  );

  ser16_sync #(.W(PTR_W)) u_w2s (
    .clk(ser_clk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  ser16_sync #(.W(PTR_W)) u_s2w (
    .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  ser16_rd_shift #(.DATA_W(WORD_W), .ADDR_W(FIFO_AW), .PREFILL(PREFILL)) u_rd (
    .clk(ser_clk), .rst(rst), .wgray_s(wgray_s), .rd_data(rd_data),
    .rgray_o(rgray), .raddr_o(raddr), .ser_o(ser_out),
    .word_clk_o(word_clk_out), .udf_o(underflow)
  );
endmodule

// File: rtl/ser16_serializer_chk.sv
module ser16_serializer_chk #(
  parameter int WORD_W = 16
) (
  input logic ser_clk,
  input logic wr_clk,
  input logic rst,
  input logic ser_out,
  input logic word_clk_out,
  input logic underflow,
  input logic overflow
);
  localparam int PH_W = $clog2(WORD_W);

  logic [7:0]      since;
  logic [PH_W-1:0] phase;

  always_ff @(posedge ser_clk) begin
    if (rst) begin
      since <= '0;
      phase <= '0;
    end else begin
      if (since != 8'hFF) since <= since + 1'b1;
      phase <= (32'(phase) == WORD_W - 1) ? '0 : phase + 1'b1;
    end
  end

  // R4: reset state on the serial side
  a_r4_reset_state: assert property (@(posedge ser_clk)
    rst |=> (!ser_out && !word_clk_out && !underflow));

  // R4: output quiet until the first load
  a_r4_quiet_start: assert property (@(posedge ser_clk) disable iff (rst)
    (32'(since) < WORD_W) |-> !ser_out);

  // R2: word-rate clock phase relative to reset release
  a_r2_word_clk_phase: assert property (@(posedge ser_clk) disable iff (rst)
    word_clk_out == (32'(phase) >= WORD_W / 2));

  // R6: underflow only appears right after a load edge
  a_r6_udf_on_load: assert property (@(posedge ser_clk) disable iff (rst)
    $rose(underflow) |-> (phase == '0));

  // R8: sticky flags
  a_r8_udf_sticky: assert property (@(posedge ser_clk) disable iff (rst)
    underflow |=> underflow);

  a_r8_ovf_sticky: assert property (@(posedge wr_clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind ser16_serializer ser16_serializer_chk #(.WORD_W(WORD_W)) u_chk (
  .ser_clk(ser_clk), .wr_clk(wr_clk), .rst(rst), .ser_out(ser_out),
  .word_clk_out(word_clk_out), .underflow(underflow), .overflow(overflow)
);

// File: tb/ser16_serializer_bench.sv
module ser16_serializer_bench;
  logic        ser_clk = 1'b0;
  logic        wr_clk  = 1'b0;
  logic        rst     = 1'b1;
  logic [15:0] wr_data = 16'h8000;
  logic        ser_out, word_clk_out, underflow, overflow;

  int   compared = 0, mismatched = 0;
  int   k = 0;                 // rising ser_clk edges since reset release
  int   writes = 0;
  int   whalf = 160;
  int   pattern = 0;
  bit   wr_run = 1'b1;
  bit   stream_on = 1'b1;
  bit   started = 1'b0;
  bit   done = 1'b0;
  logic [15:0] cur = '0;
  logic [14:0] lfsr = 15'h1ACE;
  logic [15:0] q[$];

  ser16_serializer u_ser16_serializer (
    .wr_clk(wr_clk), .wr_data(wr_data), .ser_clk(ser_clk), .rst(rst),
    .ser_out(ser_out), .word_clk_out(word_clk_out),
    .underflow(underflow), .overflow(overflow)
  );

  always #10 ser_clk = ~ser_clk;   // 50 MHz

  initial begin
    #7;
    forever begin
      #(whalf);
      if (wr_run) wr_clk = ~wr_clk;
      else        wr_clk = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge ser_clk) k <= rst ? 0 : k + 1;

  // R1: every rising wr_clk edge out of reset writes the word on the bus
  always @(posedge wr_clk) begin
    if (!rst) begin
      q.push_back(wr_data);
      writes++;
    end
  end

  // Every word carries bit 15 set so a real word is told apart from a zero fill
  always @(negedge wr_clk) begin
    lfsr <= {lfsr[13:0], lfsr[14] ^ lfsr[13]};
    if (pattern == 0) wr_data <= {1'b1, lfsr};
    else              wr_data <= 16'h8000 | ((wr_data + 16'h1357) ^ 16'h2AAA);
  end

  always @(negedge ser_clk) begin
    int pos;
    if (!rst && !done) begin
      pos = k % 16;
      check(word_clk_out == (pos >= 8), "R2 word clock", word_clk_out, pos >= 8);
      if (k < 16) begin
        check(ser_out == 1'b0, "R4 quiet before first load", ser_out, 0);
      end else if (stream_on) begin
        if (pos == 0) begin
          if (ser_out) begin
            check(q.size() > 0, "R1 loaded word was written", q.size(), 1);
            if (q.size() > 0) cur = q.pop_front();
            else              cur = 16'hFFFF;
            if (!started) begin
              check(writes >= 4, "R5 prefill before first word", writes, 4);
              started = 1'b1;
            end
          end else begin
            cur = '0;
            if (started)
              check(q.size() < 3, "R6 zero word only when empty", q.size(), 0);
          end
        end
        check(ser_out == cur[15-pos], "R3 serial bit", ser_out, cur[15-pos]);
      end
    end
  end

  task automatic do_reset();
    @(negedge ser_clk);
    rst = 1'b1;
    q.delete();
    writes  = 0;
    started = 1'b0;
    cur     = '0;
    repeat (60) @(negedge ser_clk);
    check(ser_out == 1'b0,      "R4 ser_out in reset",      ser_out, 0);
    check(word_clk_out == 1'b0, "R4 word_clk_out in reset", word_clk_out, 0);
    check(underflow == 1'b0,    "R4 R8 underflow cleared",  underflow, 0);
    check(overflow == 1'b0,     "R4 R8 overflow cleared",   overflow, 0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge ser_clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // Phase 1: matched rate, pseudo-random words
    do_reset();
    repeat (60 * 16) @(negedge ser_clk);
    check(started == 1'b1,   "R5 streaming began",          started, 1);
    check(underflow == 1'b0, "R6 no underflow at matched rate", underflow, 0);
    check(overflow == 1'b0,  "R7 no overflow at matched rate",  overflow, 0);

    // Phase 2: starve the FIFO, then resume without a new prefill
    wr_run = 1'b0;
    repeat (30 * 16) @(negedge ser_clk);
    check(underflow == 1'b1, "R6 underflow after drain", underflow, 1);
    wr_run = 1'b1;
    repeat (40 * 16) @(negedge ser_clk);
    check(underflow == 1'b1, "R8 underflow still set", underflow, 1);
    check(q.size() < 3,      "R6 stream resumed",     q.size(), 0);

    // Phase 3: write eight times faster than the read rate
    do_reset();
    stream_on = 1'b0;
    whalf = 20;
    repeat (80) @(negedge ser_clk);
    check(overflow == 1'b1, "R7 overflow on fast writes", overflow, 1);
    whalf = 160;
    repeat (40 * 16) @(negedge ser_clk);
    check(overflow == 1'b1, "R8 overflow still set", overflow, 1);

    // Phase 4: fresh start with a different pattern
    pattern = 1;
    stream_on = 1'b1;
    do_reset();
    repeat (50 * 16) @(negedge ser_clk);
    check(started == 1'b1,   "R5 streaming began again", started, 1);
    check(underflow == 1'b0, "R6 no underflow after reset", underflow, 0);
    check(overflow == 1'b0,  "R7 no overflow after reset",  overflow, 0);

    finish_run();
  end
endmodule